// File: doc/BRIEF.md
# Manchester Line Decoder with Carrier Qualification

This block turns an oversampled Manchester line into a carrier-present flag, a recovered bit clock and recovered NRZ data. It runs from one fast sampling clock at sixteen ticks per bit cell. The line arrives already digitised: `line_in` is 1 while the differential is positive. `sig_det` is a separate qualifier that shows activity on the pair.

A short sustained burst of `sig_det` raises the carrier flag. While the carrier flag is up, the decoder watches the falling line transitions of the preamble. The recovered clock starts a quarter bit after the second falling transition. From then on, every rising clock edge is placed a quarter bit after the mid-cell transition it belongs to. Data is updated on the tick that follows each rising edge. When no mid-cell transition has arrived for one and a half bit times, the carrier flag drops and both outputs go back to their rest levels.

Top module: `mdec_cs`

## Requirements
- R1: With no carrier (after reset or after a frame), `carrier` is 0, `rclk` is 0 and `rdata` is 1.
- R2: `carrier` rises on the clock edge that samples `sig_det` high for the 4th tick in a row. A run of 3 or fewer high ticks leaves `carrier` at 0.
- R3: The first rising edge of `rclk` comes exactly 4 ticks after the edge that samples the second falling line transition seen with the carrier up. No `rclk` pulse occurs before that.
- R4: Polarity: a cell whose first half is low and second half high decodes as 1, and the inverse decodes as 0. The first recovered bit is the 0 of the cell that holds the second falling transition. The bits that follow come out in line order.
- R5: While `carrier` is 1, `rdata` changes only on the tick right after a rising edge of `rclk`.
- R6: During a frame, `rclk` rises every 16 ticks and stays high for 8 ticks. One recovered bit is produced per payload cell.
- R7: A transition is taken as mid-cell only when it arrives 12 to 20 ticks after the previous accepted one. Cell-boundary transitions of repeated bits are therefore ignored.
- R8: `carrier` falls 24 ticks after the last accepted mid-cell transition. The same 24-tick limit applies when the carrier came up with no line transitions at all.
- R9: On the tick where `carrier` falls, `rclk` is already 0 and `rdata` is 1.
- R10: A low `rst_n` at a clock edge returns all outputs to the rest levels of R1, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 16 ticks per bit cell |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Digitised line, 1 while the differential is positive |
| sig_det | input | 1 | Activity qualifier from the line receiver |
| carrier | output | 1 | Carrier-present flag |
| rclk | output | 1 | Recovered bit clock |
| rdata | output | 1 | Recovered NRZ data |

## Verification
Every timed result is counted in sampling ticks from the clock edge that first sees an input change. The carrier flag is due 3 ticks after the edge that first samples `sig_det` high. The first `rclk` rise is due 4 ticks after the edge that sees the second falling transition, and each new data bit 1 tick after its `rclk` rise. The carrier drop is due 24 ticks after the last mid-cell edge. The bench drives the inputs on falling clock edges and records the tick count of each sampling edge. A monitor reads the outputs on falling edges and stores the tick of every `rclk`, `rdata` and `carrier` change. Each check then compares that stored tick with the exact expected tick, not with a window.

// File: rtl/mdec_pkg.sv
// Shared types for the Manchester decoder.
// Assumes: nothing beyond IEEE 1800-2017.
package mdec_pkg;

    // Decoder progress: waiting for carrier, hunting the preamble, locked
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } mdec_state_e;

endpackage

// File: rtl/mdec_on_qual.sv
// Carrier "on" qualifier: raises on_hit on the edge that samples the
// activity qualifier high for ON_TICKS consecutive ticks.
// Assumes: arm is high only while the decoder waits for carrier.
module mdec_on_qual #(
    parameter int ON_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic sig_det,
    output logic on_hit
);
    localparam int CW = $clog2(ON_TICKS + 1);

    logic [CW-1:0] run_cnt;

    assign on_hit = arm && sig_det && (int'(run_cnt) == ON_TICKS - 1);

    // Count consecutive high samples, restarting on any low sample
    always_ff @(posedge clk) begin
        if (!rst_n || !arm || !sig_det) begin
            run_cnt <= '0;
        end else if (int'(run_cnt) < ON_TICKS - 1) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdec_phase_trk.sv
// Phase tracker: detects line transitions, accepts the mid-cell ones
// and counts ticks since the last accepted transition. Flags a timeout
// when OFF_TICKS pass without an accepted transition.
// Assumes: while hunting, every transition is a mid-cell one (preamble).
module mdec_phase_trk #(
    parameter int OSR       = 16,
    parameter int OFF_TICKS = 24,
    parameter int PH_W      = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_in,
    input  logic            hunting,
    input  logic            restart,
    output logic            fall_seen,
    output logic            timeout,
    output logic [PH_W-1:0] ph
);
    localparam int WIN_LO = (3 * OSR) / 4;
    localparam int WIN_HI = (5 * OSR) / 4;

    logic line_q;
    logic edge_now;
    logic in_win;
    logic accept;

    // Hold the previous line sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b1;
        end else begin
            line_q <= line_in;
        end
    end

    assign edge_now  = line_in ^ line_q;
    assign in_win    = (int'(ph) >= WIN_LO - 1) && (int'(ph) <= WIN_HI - 1);
    assign accept    = edge_now && (hunting || in_win);
    assign fall_seen = accept && line_q && !line_in;
    assign timeout   = (int'(ph) == OFF_TICKS - 1) && !accept;

    // Ticks since the last accepted transition, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || restart || accept) begin
            ph <= '0;
        end else if (int'(ph) < OFF_TICKS) begin
            ph <= ph + 1'b1;
        end
    end
endmodule

// File: rtl/mdec_rx_out.sv
// Output stage: builds the recovered clock and data from the phase count.
// The clock rises a quarter bit after each accepted mid-cell transition and
// falls half a bit later. Data is sampled at the clock rise and presented
// one tick later.
// Assumes: ph restarts at every accepted mid-cell transition.
module mdec_rx_out #(
    parameter int OSR  = 16,
    parameter int PH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            locked,
    input  logic            drop,
    input  logic            line_in,
    input  logic [PH_W-1:0] ph,
    output logic            rclk,
    output logic            rdata
);
    localparam int QTR  = OSR / 4;
    localparam int HALF = OSR / 2;

    logic bit_q;

    // Drive clock and data, forcing rest levels whenever not locked
    always_ff @(posedge clk) begin
        if (!rst_n || !locked || drop) begin
            rclk  <= 1'b0;
            rdata <= 1'b1;
            bit_q <= 1'b1;
        end else begin
            if (int'(ph) == QTR - 1) begin
                rclk  <= 1'b1;
                bit_q <= line_in;
            end else if (int'(ph) == QTR + HALF - 1) begin
                rclk <= 1'b0;
            end
            if (int'(ph) == QTR) begin
                rdata <= bit_q;
            end
        end
    end
endmodule

// File: rtl/mdec_cs.sv
// Manchester decoder top: carrier qualification, preamble hunt and lock.
// The carrier comes up after a sustained qualifier. The decoder locks on
// the second falling preamble transition and drops after 1.5 bit times
// without a mid-cell transition.
// Assumes: clk runs at OSR ticks per bit cell, inputs are synchronous.
module mdec_cs
    import mdec_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int ON_TICKS   = 4,
    parameter int OFF_TICKS  = 24,
    parameter int LOCK_FALLS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic sig_det,
    output logic carrier,
    output logic rclk,
    output logic rdata
);
    localparam int PH_W = $clog2(OFF_TICKS + 1);
    localparam int FCW  = $clog2(LOCK_FALLS + 1);

    mdec_state_e     state;
    logic [FCW-1:0]  falls;
    logic            on_hit;
    logic            fall_seen;
    logic            timeout;
    logic [PH_W-1:0] ph;
    logic            drop;

    assign drop = (state != ST_IDLE) && timeout;

    mdec_on_qual #(.ON_TICKS(ON_TICKS)) u_on (
        .clk(clk), .rst_n(rst_n), .arm(state == ST_IDLE),
        .sig_det(sig_det), .on_hit(on_hit)
    );

    mdec_phase_trk #(.OSR(OSR), .OFF_TICKS(OFF_TICKS), .PH_W(PH_W)) u_ph (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .hunting(state == ST_HUNT), .restart(on_hit),
        .fall_seen(fall_seen), .timeout(timeout), .ph(ph)
    );

    mdec_rx_out #(.OSR(OSR), .PH_W(PH_W)) u_out (
        .clk(clk), .rst_n(rst_n), .locked(state == ST_LOCK), .drop(drop),
        .line_in(line_in), .ph(ph), .rclk(rclk), .rdata(rdata)
    );

    // Sequence idle -> hunt -> lock and drive the carrier flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            carrier <= 1'b0;
            falls   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (on_hit) begin
                    state   <= ST_HUNT;
                    carrier <= 1'b1;
                    falls   <= '0;
                end
                ST_HUNT: if (timeout) begin
                    state   <= ST_IDLE;
                    carrier <= 1'b0;
                end else if (fall_seen) begin
                    if (int'(falls) == LOCK_FALLS - 1) state <= ST_LOCK;
                    else falls <= falls + 1'b1;
                end
                ST_LOCK: if (timeout) begin
                    state   <= ST_IDLE;
                    carrier <= 1'b0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1
    idle_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier |-> (!rclk && rdata));

    // R2
    no_early_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sig_det) |=> !carrier);

    // R3
    clk_needs_car_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rclk) |-> carrier);

    // R5
    data_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier && !$stable(rdata)) |-> ($past(rclk) && !$past(rclk, 2)));

    // R9
    drop_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier) |-> (!rclk && rdata));
endmodule

// File: tb/mdec_cs_test.sv
module mdec_cs_test;
    localparam int OSR = 16;

    // stimulus payload, payload length, expected number of recovered bits
    localparam logic [15:0] PAY_T [4] = '{16'hFFFF, 16'h0000, 16'hA5C3, 16'h0006};
    localparam int          LEN_T [4] = '{16, 16, 16, 3};
    localparam int          NRX_T [4] = '{17, 17, 17, 4};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_in = 1'b1;
    logic sig_det = 1'b0;
    logic carrier, rclk, rdata;

    int tick = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor state
    int first_rise, last_rise, rise_cnt, per_err, chg_err, drop_err;
    int car_rise, car_fall, rx_n;
    logic [31:0] rx_bits;
    logic prv_rclk = 1'b0, prv_rdata = 1'b1, prv_car = 1'b0;

    // stimulus bookkeeping
    int sig_start, lock_tick, last_mid;

    mdec_cs uut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .sig_det(sig_det),
        .carrier(carrier), .rclk(rclk), .rdata(rdata)
    );

    always #2 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rclk && !prv_rclk) begin
            rise_cnt++;
            if (first_rise < 0) first_rise = tick;
            else if (tick - last_rise != OSR) per_err++;
            last_rise = tick;
        end
        if (!rclk && prv_rclk) begin
            if (rx_n < 32) rx_bits[rx_n] = rdata;
            rx_n++;
            if (tick - last_rise != OSR / 2) per_err++;
        end
        if (rdata != prv_rdata && carrier && tick != last_rise + 1) chg_err++;
        if (carrier && !prv_car) car_rise = tick;
        if (!carrier && prv_car) begin
            car_fall = tick;
            if (rclk || !rdata) drop_err++;
        end
        prv_rclk = rclk;
        prv_rdata = rdata;
        prv_car = carrier;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        @(posedge clk);
        first_rise = -1; last_rise = -1000; rise_cnt = 0; per_err = 0;
        chg_err = 0; drop_err = 0; car_rise = -1; car_fall = -1;
        rx_n = 0; rx_bits = '0;
    endtask

    // preamble 1,0,1,0 then payload LSB first; abort >= 0 resets mid-frame
    task automatic send_frame(input logic [15:0] pay, input int n, input int abort);
        logic [19:0] bits;
        bits = {pay, 4'b0101};
        for (int c = 0; c < 4 + n; c++) begin
            for (int h = 0; h < OSR; h++) begin
                logic lv;
                lv = (h < OSR / 2) ? ~bits[c] : bits[c];
                @(negedge clk);
                if (abort >= 0 && c == abort && h == 14) begin
                    chk(rclk == 1'b1 && rdata == 1'b0 && carrier == 1'b1, "R10",
                        {rclk, rdata, carrier}, 3'b101);
                    rst_n <= 1'b0;
                    @(negedge clk);
                    chk(rclk == 1'b0 && rdata == 1'b1 && carrier == 1'b0, "R10",
                        {rclk, rdata, carrier}, 3'b010);
                    rst_n <= 1'b1;
                    line_in <= 1'b1;
                    sig_det <= 1'b0;
                    repeat (20) @(negedge clk);
                    return;
                end
                if (c == 0 && h == 0) sig_start = tick + 1;
                if (h == OSR / 2) begin
                    last_mid = tick + 1;
                    if (c == 3) lock_tick = tick + 1;
                end
                line_in <= lv;
                sig_det <= 1'b1;
            end
        end
        @(negedge clk);
        line_in <= 1'b1;
        sig_det <= 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic frame_checks(input logic [15:0] pay, input int n, input int nrx);
        logic [31:0] mask, expv;
        mask = (32'h1 << (n + 1)) - 1;
        expv = {15'h0, pay, 1'b0} & mask;
        chk(car_rise == sig_start + 3, "R2", car_rise, sig_start + 3);
        chk(first_rise == lock_tick + 4, "R3", first_rise, lock_tick + 4);
        chk(rx_n == nrx, "R6", rx_n, nrx);
        chk((rx_bits & mask) == expv, "R4 R7", int'(rx_bits & mask), int'(expv));
        chk(per_err == 0, "R6", per_err, 0);
        chk(chg_err == 0, "R5", chg_err, 0);
        chk(car_fall == last_mid + 24, "R8", car_fall, last_mid + 24);
        chk(drop_err == 0 && rclk == 1'b0 && rdata == 1'b1, "R9",
            drop_err, 0);
    endtask

    initial begin
        // reset state (R1)
        repeat (3) @(negedge clk);
        chk(carrier == 1'b0 && rclk == 1'b0 && rdata == 1'b1, "R1",
            {carrier, rclk, rdata}, 3'b001);
        rst_n <= 1'b1;
        repeat (3) @(negedge clk);
        chk(carrier == 1'b0 && rclk == 1'b0 && rdata == 1'b1, "R1",
            {carrier, rclk, rdata}, 3'b001);

        // table of frames
        for (int v = 0; v < 4; v++) begin
            clr_mon();
            send_frame(PAY_T[v], LEN_T[v], -1);
            frame_checks(PAY_T[v], LEN_T[v], NRX_T[v]);
        end

        // R2: a 3-tick qualifier burst must not raise the carrier
        clr_mon();
        @(negedge clk); sig_det <= 1'b1;
        repeat (3) @(negedge clk);
        sig_det <= 1'b0;
        repeat (20) @(negedge clk);
        chk(car_rise == -1, "R2", car_rise, -1);

        // R8: carrier up with a quiet line times out after 24 ticks
        clr_mon();
        @(negedge clk); sig_det <= 1'b1; sig_start = tick + 1;
        repeat (6) @(negedge clk);
        sig_det <= 1'b0;
        repeat (40) @(negedge clk);
        chk(car_fall == sig_start + 27, "R8", car_fall, sig_start + 27);
        chk(rise_cnt == 0, "R3", rise_cnt, 0);
        chk(rclk == 1'b0 && rdata == 1'b1 && carrier == 1'b0, "R1",
            {carrier, rclk, rdata}, 3'b001);

        // R10: reset in the middle of a locked frame, then a clean frame
        clr_mon();
        send_frame(16'h0000, 16, 6);
        clr_mon();
        send_frame(PAY_T[2], LEN_T[2], -1);
        frame_checks(PAY_T[2], LEN_T[2], NRX_T[2]);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", tick, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule